// File: doc/BRIEF.md
# QPSK Decision-Directed Carrier Phase Tracker

This block takes complex QPSK samples at one sample per symbol, after downconversion and matched filtering, and removes an unknown, slowly varying carrier phase. Each accepted sample is rotated by the negative of a running phase estimate. A hard two-bit decision is made on the rotated sample, and a decision-directed phase error is formed from it. A proportional-plus-integral loop filter turns that error into a phase step, which a 16-bit wrapping phase accumulator adds up. The filter is tuned for a second-order loop with a noise bandwidth of 0.02 of the symbol rate and a damping of 0.7071.

The decisions are only four-fold symmetric, so the loop can settle at any of four phases 90 degrees apart. Its decisions may then be a rotated copy of the transmitted symbols. Resolving that ambiguity, and judging lock from the monitored loop-filter output, is left to logic downstream. The loop starts unlocked after reset and pulls in over the first part of a burst.

Top module: `qpsk_phase_tracker`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, out_valid is 0. out_i, out_q, out_dec and out_lf are 0, and the phase estimate and integrator are 0. The first sample after reset is therefore passed through unrotated.
- R2: A sample presented with in_valid high in cycle n appears with out_valid high in cycle n+2, for exactly one cycle per sample, in input order.
- R3: The rotated output is y = x·e^(−jθ), where θ = 2π·acc[15:10]/64. The trig values are round(16384·sin) and round(16384·cos). Then out_i = (in_i·cos + in_q·sin) >>> 14 and out_q = (in_q·cos − in_i·sin) >>> 14, with arithmetic (floor) shifts. The sample is rotated by the accumulator value left by all earlier samples.
- R4: out_dec[1] is 1 when out_i < 0, and out_dec[0] is 1 when out_q < 0. Zero counts as non-negative.
- R5: The phase error is e = out_q·s(out_i) − out_i·s(out_q), where s(v) = +1 for v ≥ 0 and −1 otherwise. It is zero in any cycle without a sample.
- R6: With K1 = 8666 and K2 = 231 (signed, 15 fraction bits), the integrator becomes integ + K2·e. The output is out_lf = (K1·e + new integ) >>> 15.
- R7: The phase accumulator adds out_lf modulo 2^16 on each sample, and wraps through zero in both directions.
- R8: Cycles with in_valid low change no state. Gaps between samples leave every later output unchanged.
- R9: The integrator saturates at −2^23 and 2^23−1 instead of wrapping.
- R10: For a constant 100-degree carrier offset, the loop settles at a 90-degree rotation. After pull-in, a transmitted symbol (si, sq) is decided as (−sq, si).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample is present on in_i/in_q |
| in_i | input | 12 | In-phase sample, signed, ±1 = ±1024 |
| in_q | input | 12 | Quadrature sample, signed |
| out_valid | output | 1 | Result fields are new this cycle |
| out_i | output | 13 | Rotated in-phase sample, signed |
| out_q | output | 13 | Rotated quadrature sample, signed |
| out_dec | output | 2 | Hard decision {I negative, Q negative} |
| out_lf | output | 16 | Loop-filter output (phase step), signed |

## Verification
Integrator clamping and accumulator wrap-around can fall in the same symbol update. Both are then resolved in one cycle, from one error value. This case is provoked with a constant frequency ramp of 2.5 degrees per symbol, which is beyond the integrator's range. The ramp drives the integrator to its limit while the accumulator keeps spinning through zero. A reference model in the bench predicts every rotated sample, decision and filter output, so a clamp that wraps or a phase that fails to wrap shows up as a miscompare on later symbols. The bench also confirms that both events occurred during the run.

// File: rtl/qpt_pkg.sv
package qpt_pkg;

    localparam int TRIG_W    = 16;
    localparam int TRIG_FRAC = 14;
    localparam int LUT_IDX_W = 4;

    typedef enum logic [1:0] {
        QUAD_0   = 2'd0,
        QUAD_90  = 2'd1,
        QUAD_180 = 2'd2,
        QUAD_270 = 2'd3
    } quad_e;

    // quarter-wave sine, 17 points over 0..90 degrees, scaled by 2^14
    function automatic logic signed [TRIG_W-1:0] lut_sin(input logic [LUT_IDX_W:0] k);
        case (k)
            5'd0:    return 16'sd0;
            5'd1:    return 16'sd1606;
            5'd2:    return 16'sd3196;
            5'd3:    return 16'sd4756;
            5'd4:    return 16'sd6270;
            5'd5:    return 16'sd7723;
            5'd6:    return 16'sd9102;
            5'd7:    return 16'sd10394;
            5'd8:    return 16'sd11585;
            5'd9:    return 16'sd12665;
            5'd10:   return 16'sd13623;
            5'd11:   return 16'sd14449;
            5'd12:   return 16'sd15137;
            5'd13:   return 16'sd15679;
            5'd14:   return 16'sd16069;
            5'd15:   return 16'sd16305;
            default: return 16'sd16384;
        endcase
    endfunction

endpackage

// File: rtl/qpt_sincos.sv
module qpt_sincos
    import qpt_pkg::*;
#(
    parameter int ACC_W = 16
)(
    input  logic [ACC_W-1:0]        phase,
    output logic signed [TRIG_W-1:0] sin_o,
    output logic signed [TRIG_W-1:0] cos_o
);
    localparam logic [LUT_IDX_W:0] QUARTER = (LUT_IDX_W+1)'(1 << LUT_IDX_W);

    quad_e                   quad;
    logic [LUT_IDX_W-1:0]    idx;
    logic signed [TRIG_W-1:0] s0, c0;

    always_comb begin
        quad = quad_e'(phase[ACC_W-1 -: 2]);
        idx  = phase[ACC_W-3 -: LUT_IDX_W];
        s0   = lut_sin({1'b0, idx});
        c0   = lut_sin(QUARTER - {1'b0, idx});
        unique case (quad)
            QUAD_0:   begin sin_o =  s0; cos_o =  c0; end
            QUAD_90:  begin sin_o =  c0; cos_o = -s0; end
            QUAD_180: begin sin_o = -s0; cos_o = -c0; end
            QUAD_270: begin sin_o = -c0; cos_o =  s0; end
        endcase
    end

endmodule

// File: rtl/qpt_rotator.sv
module qpt_rotator
    import qpt_pkg::*;
#(
    parameter int DATA_W = 12,
    localparam int YW    = DATA_W + 1,
    localparam int PW    = DATA_W + TRIG_W
)(
    input  logic signed [DATA_W-1:0] xi,
    input  logic signed [DATA_W-1:0] xq,
    input  logic signed [TRIG_W-1:0] sin_i,
    input  logic signed [TRIG_W-1:0] cos_i,
    output logic signed [YW-1:0]     yi,
    output logic signed [YW-1:0]     yq
);
    logic signed [PW-1:0] p_ic, p_qs, p_qc, p_is;
    logic signed [PW:0]   sum_i, sum_q, sh_i, sh_q;

    always_comb begin
        p_ic  = xi * cos_i;
        p_qs  = xq * sin_i;
        p_qc  = xq * cos_i;
        p_is  = xi * sin_i;
        sum_i = (PW+1)'(p_ic) + (PW+1)'(p_qs);
        sum_q = (PW+1)'(p_qc) - (PW+1)'(p_is);
        sh_i  = sum_i >>> TRIG_FRAC;
        sh_q  = sum_q >>> TRIG_FRAC;
        yi    = sh_i[YW-1:0];
        yq    = sh_q[YW-1:0];
    end

endmodule

// File: rtl/qpt_phase_det.sv
module qpt_phase_det #(
    parameter int YW     = 13,
    localparam int ERR_W = YW + 1
)(
    input  logic                    valid,
    input  logic signed [YW-1:0]    yi,
    input  logic signed [YW-1:0]    yq,
    output logic [1:0]              dec,
    output logic signed [ERR_W-1:0] err
);
    logic signed [ERR_W-1:0] yi_x, yq_x, t_q, t_i;

    always_comb begin
        yi_x = ERR_W'(yi);
        yq_x = ERR_W'(yq);
        dec  = {yi[YW-1], yq[YW-1]};
        t_q  = yi[YW-1] ? -yq_x : yq_x;
        t_i  = yq[YW-1] ? -yi_x : yi_x;
        err  = valid ? (t_q - t_i) : '0;
    end

endmodule

// File: rtl/qpt_loop_filter.sv
module qpt_loop_filter #(
    parameter int ERR_W     = 14,
    parameter int GAIN_W    = 16,
    parameter int GAIN_FRAC = 15,
    parameter int K1        = 8666,
    parameter int K2        = 231,
    parameter int INT_W     = 24,
    localparam int PW       = GAIN_W + ERR_W,
    localparam int SW       = PW + 1,
    localparam int LF_W     = SW - GAIN_FRAC
)(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd,
    input  logic signed [ERR_W-1:0] err,
    output logic signed [LF_W-1:0]  lf
);
    localparam logic signed [GAIN_W-1:0] K1_C   = GAIN_W'(K1);
    localparam logic signed [GAIN_W-1:0] K2_C   = GAIN_W'(K2);
    localparam logic signed [SW-1:0]     SAT_HI = SW'((64'sd1 <<< (INT_W-1)) - 64'sd1);
    localparam logic signed [SW-1:0]     SAT_LO = SW'(-(64'sd1 <<< (INT_W-1)));

    logic signed [INT_W-1:0] integ, integ_nx;
    logic signed [PW-1:0]    p_prop, p_int;
    logic signed [SW-1:0]    s_int, s_sat, lf_sum, lf_sh;

    always_comb begin
        p_prop = K1_C * err;
        p_int  = K2_C * err;
        s_int  = SW'(integ) + SW'(p_int);
        if (s_int > SAT_HI)      s_sat = SAT_HI;
        else if (s_int < SAT_LO) s_sat = SAT_LO;
        else                     s_sat = s_int;
        integ_nx = s_sat[INT_W-1:0];
        lf_sum   = SW'(p_prop) + SW'(integ_nx);
        lf_sh    = lf_sum >>> GAIN_FRAC;
        lf       = lf_sh[LF_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n)   integ <= '0;
        else if (upd) integ <= integ_nx;
    end

    AST_INTEG_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> integ == $past(integ)); // R8

    AST_INTEG_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && err > 0) |=> integ >= $past(integ)); // R9

    AST_INTEG_NO_WRAP_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && err < 0) |=> integ <= $past(integ)); // R9

endmodule

// File: rtl/qpsk_phase_tracker.sv
module qpsk_phase_tracker
    import qpt_pkg::*;
#(
    parameter int DATA_W    = 12,
    parameter int ACC_W     = 16,
    parameter int GAIN_W    = 16,
    parameter int GAIN_FRAC = 15,
    parameter int K1        = 8666,
    parameter int K2        = 231,
    parameter int INT_W     = 24,
    localparam int YW       = DATA_W + 1,
    localparam int ERR_W    = YW + 1,
    localparam int LF_W     = GAIN_W + ERR_W + 1 - GAIN_FRAC
)(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic signed [DATA_W-1:0] in_i,
    input  logic signed [DATA_W-1:0] in_q,
    output logic                     out_valid,
    output logic signed [YW-1:0]     out_i,
    output logic signed [YW-1:0]     out_q,
    output logic [1:0]               out_dec,
    output logic signed [LF_W-1:0]   out_lf
);
    logic                     va;
    logic signed [DATA_W-1:0] xi_a, xq_a;
    logic [ACC_W-1:0]         acc;
    logic signed [TRIG_W-1:0] sin_w, cos_w;
    logic signed [YW-1:0]     yi_w, yq_w;
    logic [1:0]               dec_w;
    logic signed [ERR_W-1:0]  err_w;
    logic signed [LF_W-1:0]   lf_w;

    // stage A: capture the sample
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va   <= 1'b0;
            xi_a <= '0;
            xq_a <= '0;
        end else begin
            va <= in_valid;
            if (in_valid) begin
                xi_a <= in_i;
                xq_a <= in_q;
            end
        end
    end

    qpt_sincos #(.ACC_W(ACC_W)) u_sincos (
        .phase (acc),
        .sin_o (sin_w),
        .cos_o (cos_w)
    );

    qpt_rotator #(.DATA_W(DATA_W)) u_rot (
        .xi    (xi_a),
        .xq    (xq_a),
        .sin_i (sin_w),
        .cos_i (cos_w),
        .yi    (yi_w),
        .yq    (yq_w)
    );

    qpt_phase_det #(.YW(YW)) u_pd (
        .valid (va),
        .yi    (yi_w),
        .yq    (yq_w),
        .dec   (dec_w),
        .err   (err_w)
    );

    qpt_loop_filter #(
        .ERR_W     (ERR_W),
        .GAIN_W    (GAIN_W),
        .GAIN_FRAC (GAIN_FRAC),
        .K1        (K1),
        .K2        (K2),
        .INT_W     (INT_W)
    ) u_lf (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (va),
        .err   (err_w),
        .lf    (lf_w)
    );

    // stage B: register results, advance the phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc       <= '0;
            out_valid <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
            out_dec   <= '0;
            out_lf    <= '0;
        end else begin
            out_valid <= va;
            if (va) begin
                acc     <= acc + lf_w[ACC_W-1:0];
                out_i   <= yi_w;
                out_q   <= yq_w;
                out_dec <= dec_w;
                out_lf  <= lf_w;
            end
        end
    end

    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid)) |=> out_valid); // R2

    AST_ACC_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !va |=> acc == $past(acc)); // R8

    AST_DEC_MATCHES_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_dec[1] == out_i[YW-1] && out_dec[0] == out_q[YW-1])); // R4

endmodule

// File: tb/qpsk_phase_tracker_bench.sv
`timescale 1ns/1ps
module qpsk_phase_tracker_bench;

    localparam int  INT_W_B = 24;
    localparam real PI      = 3.14159265358979;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic signed [11:0] in_i = '0;
    logic signed [11:0] in_q = '0;
    logic out_valid;
    logic signed [12:0] out_i, out_q;
    logic [1:0] out_dec;
    logic signed [15:0] out_lf;

    always #10 clk = ~clk;

    qpsk_phase_tracker u_qpsk_phase_tracker (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_i(out_i), .out_q(out_q),
        .out_dec(out_dec), .out_lf(out_lf)
    );

    typedef struct {
        int yi; int yq; int dec; int lf; int cyc; bit lk; int lkdec;
    } exp_t;

    exp_t   exp_q[$];
    int     n_chk = 0;
    int     n_fail = 0;
    int     cyc = 0;
    int     m_acc = 0;
    longint m_integ = 0;
    bit     saw_sat = 0;
    bit     saw_wrap = 0;
    bit     done = 0;
    int     lfsr = 32'h1ACE5;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int rnd(real x);
        if (x >= 0.0) return $rtoi(x + 0.5);
        return -$rtoi(-x + 0.5);
    endfunction

    function automatic int clip12(int v);
        if (v > 2047) return 2047;
        if (v < -2048) return -2048;
        return v;
    endfunction

    task automatic check(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, expv, $time);
        end
    endtask

    // reference model of one symbol update, from the requirements
    task automatic model(input int xi, input int xq, output exp_t e);
        real    ang;
        longint c, s, yi, yq, er, lf, nxt, lim;
        ang = 2.0 * PI * real'(m_acc >> 10) / 64.0;
        c  = longint'($floor(16384.0 * $cos(ang) + 0.5));
        s  = longint'($floor(16384.0 * $sin(ang) + 0.5));
        yi = (longint'(xi) * c + longint'(xq) * s) >>> 14;
        yq = (longint'(xq) * c - longint'(xi) * s) >>> 14;
        er = ((yi >= 0) ? yq : -yq) - ((yq >= 0) ? yi : -yi);
        lim = longint'(1) << (INT_W_B - 1);
        m_integ = m_integ + 231 * er;
        if (m_integ > lim - 1) begin m_integ = lim - 1; saw_sat = 1; end
        if (m_integ < -lim)    begin m_integ = -lim;    saw_sat = 1; end
        lf = (8666 * er + m_integ) >>> 15;
        nxt = longint'(m_acc) + lf;
        if (nxt > 65535 || nxt < 0) saw_wrap = 1;
        m_acc = int'(nxt & 64'hFFFF);
        e.yi = int'(yi); e.yq = int'(yq);
        e.dec = ((yi < 0) ? 2 : 0) + ((yq < 0) ? 1 : 0);
        e.lf = int'(lf);
        e.lk = 0; e.lkdec = 0;
    endtask

    task automatic send(int xi, int xq, bit lk, int lkdec);
        exp_t e;
        @(negedge clk);
        in_valid = 1'b1;
        in_i = 12'(xi);
        in_q = 12'(xq);
        model(xi, xq, e);
        e.cyc = cyc + 2;
        e.lk = lk;
        e.lkdec = lkdec;
        exp_q.push_back(e);
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    task automatic next_sym(output int si, output int sq);
        lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'h80200003 : 0);
        si = lfsr[3] ? 1 : -1;
        sq = lfsr[9] ? 1 : -1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        idle(3);
        // R1: cleared outputs during reset
        check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
        check(out_i == 0 && out_q == 0, "R1 out_i/out_q in reset", int'(out_i), 0);
        check(out_dec == 0 && out_lf == 0, "R1 out_dec/out_lf in reset", int'(out_lf), 0);
        m_acc = 0;
        m_integ = 0;
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 out_valid after release", int'(out_valid), 0);
    endtask

    // monitor: compare each result against the queued prediction
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                check(0, "R2 unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(cyc == e.cyc, "R2 latency cycle", cyc, e.cyc);
                check(int'(out_i) == e.yi, "R3 out_i", int'(out_i), e.yi);
                check(int'(out_q) == e.yq, "R3 out_q", int'(out_q), e.yq);
                check(int'(out_dec) == e.dec, "R4 out_dec", int'(out_dec), e.dec);
                check(int'(out_lf) == e.lf, "R5 R6 R7 out_lf", int'(out_lf), e.lf);
                if (e.lk)
                    check(int'(out_dec) == e.lkdec, "R10 rotated decision", int'(out_dec), e.lkdec);
            end
        end
    end

    task automatic drain();
        idle(4);
        check(exp_q.size() == 0, "R2 outputs all delivered", exp_q.size(), 0);
    endtask

    initial begin : watchdog
        wait (cyc == 150000);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int si, sq, g;
        real ph, ca, sa;
        do_reset();

        // R1 R3: first sample with zero phase passes unrotated
        send(700, -300, 0, 0);
        idle(1);
        @(negedge clk);
        check(int'(out_i) == 700 && int'(out_q) == -300, "R1 R3 identity first sample",
              int'(out_i), 700);
        drain();

        // R10: constant 100-degree offset, back-to-back symbols
        do_reset();
        ca = $cos(100.0 * PI / 180.0);
        sa = $sin(100.0 * PI / 180.0);
        for (int k = 0; k < 500; k++) begin
            next_sym(si, sq);
            send(clip12(rnd(1024.0 * (si * ca - sq * sa))),
                 clip12(rnd(1024.0 * (si * sa + sq * ca))),
                 k >= 450, (sq > 0 ? 2 : 0) + (si < 0 ? 1 : 0));
        end
        drain();

        // R8 R5 R3: irregular gaps, zero and full-scale samples
        do_reset();
        send(0, 0, 0, 0);
        send(0, 500, 0, 0);
        send(500, 0, 0, 0);
        idle(2);
        send(2047, 2047, 0, 0);
        send(-2048, -2048, 0, 0);
        idle(1);
        send(2047, -2048, 0, 0);
        send(-2048, 2047, 0, 0);
        ca = $cos(-30.0 * PI / 180.0);
        sa = $sin(-30.0 * PI / 180.0);
        for (int k = 0; k < 80; k++) begin
            next_sym(si, sq);
            send(clip12(rnd(1024.0 * (si * ca - sq * sa))),
                 clip12(rnd(1024.0 * (si * sa + sq * ca))), 0, 0);
            g = (lfsr >> 4) & 3;
            if (g != 0) idle(g);
        end
        drain();

        // R9 R7: frequency ramp beyond integrator range
        do_reset();
        saw_sat = 0;
        saw_wrap = 0;
        ph = 0.0;
        for (int k = 0; k < 800; k++) begin
            next_sym(si, sq);
            ca = $cos(ph);
            sa = $sin(ph);
            send(clip12(rnd(1024.0 * (si * ca - sq * sa))),
                 clip12(rnd(1024.0 * (si * sa + sq * ca))), 0, 0);
            ph = ph + 2.5 * PI / 180.0;
            if (ph > 2.0 * PI) ph = ph - 2.0 * PI;
        end
        drain();
        check(saw_sat, "R9 integrator limit reached in ramp", int'(saw_sat), 1);
        check(saw_wrap, "R7 accumulator wrap reached in ramp", int'(saw_wrap), 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule